// File: doc/BRIEF.md
# Half-Duplex Transmit Access Controller

This block decides when a queued Ethernet frame may go on the wire and what happens when it meets another station. The client raises a frame request. The block waits until the medium has been quiet for a full interframe gap, then raises transmit-enable. While the frame is on the air it watches for collisions. An early collision makes the block send a short jam, choose a random truncated binary exponential backoff and retry the frame. A collision that comes too late, or one collision too many, ends with the frame being discarded. A reason code on the drop output tells the two cases apart.

All timing is counted in bit times, given by a one-cycle `bit_tick` strobe from the serializer clock domain logic. The serializer reports the end of a good frame with `frame_done`. A full-duplex mode input makes the block ignore carrier and collision, so that only the interframe gap is enforced. Gap length, slot length, jam length, attempt limit and backoff exponent cap are parameters. Their defaults are 96, 512, 32, 16 and 10.

Top module: `txdefer_ctrl`

## Requirements
- R1: After reset, `tx_en`, `jam`, `drop` and `retry` are low and `drop_reason` is 0.
- R2: After a frame ends with `frame_done`, `tx_en` stays low for at least IFG_BITS bit ticks before the next frame starts. With a tick every cycle and an idle medium, the restart follows within IFG_BITS+3 cycles.
- R3: In half-duplex mode a frame never starts while `crs` is high. After a collision, the gap is counted from the fall of `crs`, not from the end of the block's own jam.
- R4: A collision seen in half-duplex mode during the first SLOT_BITS ticks of a transmission raises `jam`, with `tx_en` still high, for exactly JAM_BITS ticks. Then `retry` pulses for one cycle in the cycle that `jam` falls.
- R5: After the n-th collision on a frame, the block waits r slots of SLOT_BITS ticks, where r is drawn from 0 to 2^min(n,BACKOFF_CAP)−1 by a free-running LFSR. The wait is followed by the normal deferral.
- R6: The collision that brings a frame's count to ATTEMPT_LIMIT ends in a one-cycle `drop` with `drop_reason` = 01 and no `retry`. The count is cleared when a frame ends, so each new frame again gets ATTEMPT_LIMIT attempts.
- R7: A collision seen after SLOT_BITS or more ticks of transmission is late. The block jams for JAM_BITS ticks, then pulses `drop` with `drop_reason` = 10 and never retries.
- R8: With `full_duplex` high, `crs` and `col` have no effect: a frame starts with `crs` high, no jam is produced, and only the IFG_BITS gap is enforced.
- R9: All gap, slot and jam timing advances only on cycles where `bit_tick` is high.
- R10: `drop` and `retry` are single-cycle pulses and never high together. `drop_reason` is 00 whenever `drop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One bit time has elapsed |
| full_duplex | input | 1 | 1: ignore carrier and collision |
| crs | input | 1 | Carrier sense from the medium |
| col | input | 1 | Collision detected |
| frame_req | input | 1 | A frame is waiting to be sent |
| frame_done | input | 1 | The current frame finished without collision |
| tx_en | output | 1 | Frame or jam is being transmitted |
| jam | output | 1 | Jam pattern is being sent |
| drop | output | 1 | One-cycle pulse: frame discarded |
| drop_reason | output | 2 | 01 too many collisions, 10 late collision |
| retry | output | 1 | One-cycle pulse: backoff started, frame will be retried |

## Verification
The hardest state to reach is the attempt limit. Sixteen consecutive collisions must hit one frame, each after a random backoff whose length the bench cannot predict. The bench therefore reacts to the design instead of scripting times. It waits for every `tx_en` rise, forces a collision two cycles into it, and checks each restart delay against the bound for that attempt number. Shortened slot, gap and exponent-cap parameters keep the whole run short. It repeats the run on a second frame to show that the collision count starts again from zero.

// File: rtl/txdefer_pkg.sv
package txdefer_pkg;

    localparam int LFSR_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TX,
        ST_JAM,
        ST_BACKOFF
    } txd_state_e;

    typedef enum logic [1:0] {
        DROP_NONE   = 2'd0,
        DROP_EXCESS = 2'd1,
        DROP_LATE   = 2'd2
    } drop_why_e;

    // Galois LFSR, polynomial x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

endpackage

// File: rtl/txdefer_gap.sv
module txdefer_gap #(
    parameter int IFG_BITS = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic clear,
    output logic gap_met
);
    localparam int GW = $clog2(IFG_BITS + 1);

    logic [GW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            quiet_cnt <= '0;
        end else if (bit_tick && quiet_cnt != GW'(IFG_BITS)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign gap_met = (quiet_cnt == GW'(IFG_BITS));
endmodule

// File: rtl/txdefer_backoff.sv
module txdefer_backoff
    import txdefer_pkg::*;
#(
    parameter int SLOT_BITS   = 512,
    parameter int BACKOFF_CAP = 10,
    parameter int CW          = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_tick,
    input  logic          load,
    input  logic [CW-1:0] attempts,
    output logic          done
);
    localparam int SW = $clog2(SLOT_BITS);

    logic [LFSR_W-1:0]      lfsr;
    logic [BACKOFF_CAP-1:0] draw;
    logic [BACKOFF_CAP-1:0] slots_left;
    logic [SW-1:0]          slot_bit;

    always_ff @(posedge clk) begin
        if (rst) lfsr <= 16'hACE1;
        else     lfsr <= lfsr_next(lfsr);
    end

    // keep only the low min(attempts, cap) bits of the random word
    always_comb begin
        for (int i = 0; i < BACKOFF_CAP; i++) begin
            draw[i] = lfsr[i] & (i < int'(attempts));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_left <= '0;
            slot_bit   <= '0;
        end else if (load) begin
            slots_left <= draw;
            slot_bit   <= '0;
        end else if (bit_tick && slots_left != '0) begin
            if (slot_bit == SW'(SLOT_BITS - 1)) begin
                slot_bit   <= '0;
                slots_left <= slots_left - 1'b1;
            end else begin
                slot_bit <= slot_bit + 1'b1;
            end
        end
    end

    assign done = (slots_left == '0);
endmodule

// File: rtl/txdefer_ctrl.sv
module txdefer_ctrl
    import txdefer_pkg::*;
#(
    parameter int IFG_BITS      = 96,
    parameter int SLOT_BITS     = 512,
    parameter int JAM_BITS      = 32,
    parameter int ATTEMPT_LIMIT = 16,
    parameter int BACKOFF_CAP   = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       full_duplex,
    input  logic       crs,
    input  logic       col,
    input  logic       frame_req,
    input  logic       frame_done,
    output logic       tx_en,
    output logic       jam,
    output logic       drop,
    output logic [1:0] drop_reason,
    output logic       retry
);
    localparam int CW = $clog2(ATTEMPT_LIMIT + 1);
    localparam int TW = $clog2(SLOT_BITS + 1);
    localparam int JW = $clog2(JAM_BITS);

    txd_state_e    state;
    logic [TW-1:0] tx_bits;
    logic [JW-1:0] jam_cnt;
    logic [CW-1:0] col_cnt;
    logic          late_hit;
    logic          carrier_busy, col_seen, gap_met, bo_done, bo_load, jam_last, on_air;

    assign carrier_busy = !full_duplex && crs;
    assign col_seen     = !full_duplex && col;
    assign on_air       = (state == ST_TX) || (state == ST_JAM);
    assign jam_last     = bit_tick && (jam_cnt == JW'(JAM_BITS - 1));
    assign bo_load      = (state == ST_JAM) && jam_last && !late_hit
                          && (col_cnt != CW'(ATTEMPT_LIMIT));

    txdefer_gap #(.IFG_BITS(IFG_BITS)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .clear    (on_air || carrier_busy),
        .gap_met  (gap_met)
    );

    txdefer_backoff #(
        .SLOT_BITS   (SLOT_BITS),
        .BACKOFF_CAP (BACKOFF_CAP),
        .CW          (CW)
    ) u_bo (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .load     (bo_load),
        .attempts (col_cnt),
        .done     (bo_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            tx_bits     <= '0;
            jam_cnt     <= '0;
            col_cnt     <= '0;
            late_hit    <= 1'b0;
            drop        <= 1'b0;
            retry       <= 1'b0;
            drop_reason <= DROP_NONE;
        end else begin
            drop        <= 1'b0;
            retry       <= 1'b0;
            drop_reason <= DROP_NONE;
            unique case (state)
                ST_IDLE: begin
                    if (frame_req && gap_met && !carrier_busy) begin
                        state   <= ST_TX;
                        tx_bits <= '0;
                    end
                end
                ST_TX: begin
                    if (frame_done) begin
                        state   <= ST_IDLE;
                        col_cnt <= '0;
                    end else if (col_seen) begin
                        state    <= ST_JAM;
                        jam_cnt  <= '0;
                        late_hit <= (tx_bits >= TW'(SLOT_BITS));
                        if (tx_bits < TW'(SLOT_BITS)) col_cnt <= col_cnt + 1'b1;
                    end else if (bit_tick && tx_bits != TW'(SLOT_BITS)) begin
                        tx_bits <= tx_bits + 1'b1;
                    end
                end
                ST_JAM: begin
                    if (jam_last) begin
                        if (late_hit) begin
                            state       <= ST_IDLE;
                            drop        <= 1'b1;
                            drop_reason <= DROP_LATE;
                            col_cnt     <= '0;
                        end else if (col_cnt == CW'(ATTEMPT_LIMIT)) begin
                            state       <= ST_IDLE;
                            drop        <= 1'b1;
                            drop_reason <= DROP_EXCESS;
                            col_cnt     <= '0;
                        end else begin
                            state <= ST_BACKOFF;
                            retry <= 1'b1;
                        end
                    end else if (bit_tick) begin
                        jam_cnt <= jam_cnt + 1'b1;
                    end
                end
                ST_BACKOFF: begin
                    if (bo_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_en = on_air;
    assign jam   = (state == ST_JAM);
endmodule

// File: rtl/txdefer_chk.sv
module txdefer_chk (
    input logic       clk,
    input logic       rst,
    input logic       full_duplex,
    input logic       crs,
    input logic       tx_en,
    input logic       jam,
    input logic       drop,
    input logic [1:0] drop_reason,
    input logic       retry
);
    // R10
    drop_retry_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(drop && retry));

    // R10
    drop_single_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> !drop);

    // R10
    reason_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !drop |-> drop_reason == 2'd0);

    // R4
    jam_on_air_chk: assert property (@(posedge clk) disable iff (rst)
        jam |-> tx_en);

    // R4
    retry_after_jam_chk: assert property (@(posedge clk) disable iff (rst)
        retry |-> $fell(jam));

    // R8
    no_fdx_jam_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(jam) |-> !$past(full_duplex));

    // R3
    start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_en) && !jam) |-> ($past(full_duplex) || !$past(crs)));
endmodule

bind txdefer_ctrl txdefer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .full_duplex (full_duplex),
    .crs         (crs),
    .tx_en       (tx_en),
    .jam         (jam),
    .drop        (drop),
    .drop_reason (drop_reason),
    .retry       (retry)
);

// File: tb/sim_txdefer_ctrl.sv
`timescale 1ns/1ps
module sim_txdefer_ctrl;
    localparam int IFG  = 12;
    localparam int SLOT = 16;
    localparam int JAMB = 4;
    localparam int LIM  = 16;
    localparam int CAP  = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, bit_tick, full_duplex, crs, col, frame_req, frame_done;
    logic tx_en, jam, drop, retry;
    logic [1:0] drop_reason;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_every = 1;
    int phase = 0;
    bit finished = 1'b0;

    txdefer_ctrl #(
        .IFG_BITS(IFG), .SLOT_BITS(SLOT), .JAM_BITS(JAMB),
        .ATTEMPT_LIMIT(LIM), .BACKOFF_CAP(CAP)
    ) u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .full_duplex(full_duplex),
        .crs(crs), .col(col), .frame_req(frame_req), .frame_done(frame_done),
        .tx_en(tx_en), .jam(jam), .drop(drop), .drop_reason(drop_reason),
        .retry(retry)
    );

    initial begin
        bit_tick = 1'b1;
        forever begin
            @(negedge clk);
            phase++;
            bit_tick = (phase % tick_every) == 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tx(output int cyc, input int limit);
        cyc = 0;
        while (!tx_en && cyc < limit) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // one-cycle collision, then follow the jam to its end
    task automatic collide(output int jlen, output int off_air);
        col = 1'b1;
        step(1);
        col = 1'b0;
        jlen = 0;
        off_air = 0;
        while (jam && jlen < 100) begin
            if (!tx_en) off_air++;
            jlen++;
            step(1);
        end
    endtask

    task automatic finish_frame();
        frame_done = 1'b1;
        step(1);
        frame_done = 1'b0;
        frame_req  = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        rst = 1'b1; full_duplex = 1'b0; crs = 1'b0; col = 1'b0;
        frame_req = 1'b0; frame_done = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        chk(!tx_en && !jam && !drop && !retry && drop_reason == 2'd0, "R1 reset outputs",
            {tx_en, jam, drop, retry}, 0);
    endtask

    task automatic t_gap();
        int d;
        frame_req = 1'b1;
        wait_tx(d, 200);
        chk(tx_en, "R2 first start", tx_en, 1);
        step(5);
        frame_done = 1'b1;
        step(1);
        frame_done = 1'b0;
        chk(!tx_en, "R2 tx ends on done", tx_en, 0);
        wait_tx(d, 200);
        chk(d >= IFG && d <= IFG + 3, "R2 back-to-back gap", d, IFG + 1);
        step(3);
        finish_frame();
    endtask

    task automatic t_defer_crs();
        int d;
        bit seen = 1'b0;
        crs = 1'b1;
        frame_req = 1'b1;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (tx_en) seen = 1'b1;
        end
        chk(!seen, "R3 no start under carrier", seen, 0);
        crs = 1'b0;
        wait_tx(d, 200);
        chk(d >= IFG && d <= IFG + 3, "R3 gap from carrier fall", d, IFG + 2);
        step(3);
        finish_frame();
    endtask

    task automatic t_early_col();
        int d, jlen, off;
        bit seen = 1'b0;
        frame_req = 1'b1;
        wait_tx(d, 200);
        step(3);
        crs = 1'b1;
        collide(jlen, off);
        chk(jlen == JAMB, "R4 jam length", jlen, JAMB);
        chk(off == 0, "R4 tx_en during jam", off, 0);
        chk(retry && !drop, "R4 retry at jam end", {retry, drop}, 2);
        step(1);
        chk(!retry, "R10 retry single cycle", retry, 0);
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (tx_en) seen = 1'b1;
        end
        chk(!seen, "R3 deferral after collision", seen, 0);
        crs = 1'b0;
        wait_tx(d, 200);
        chk(d >= IFG && d <= IFG + 3, "R3 retry gap from carrier fall", d, IFG + 2);
        step(2);
        finish_frame();
    endtask

    task automatic t_excess(output int attempts, output int reason, output int maxdel);
        int d, jlen, off, bound, ex;
        attempts = 0; reason = 0; maxdel = 0;
        frame_req = 1'b1;
        wait_tx(d, 300);
        while (attempts < 20) begin
            step(2);
            collide(jlen, off);
            attempts++;
            if (drop) begin
                reason = drop_reason;
                chk(!retry, "R6 no retry on limit", retry, 0);
                break;
            end
            chk(retry, "R5 retry after early collision", retry, 1);
            wait_tx(d, 5000);
            ex = (attempts < CAP) ? attempts : CAP;
            bound = (1 << ex) * SLOT + IFG + 4;
            chk(tx_en && d <= bound, "R5 backoff bound", d, bound);
            if (d > maxdel) maxdel = d;
        end
        frame_req = 1'b0;
        step(IFG + 4);
    endtask

    task automatic t_limit();
        int a, r, m;
        t_excess(a, r, m);
        chk(a == LIM, "R6 attempts to drop", a, LIM);
        chk(r == 1, "R6 excess reason code", r, 1);
        chk(m > IFG + 4, "R5 randomized backoff", m, IFG + 5);
        t_excess(a, r, m);
        chk(a == LIM, "R6 count cleared for next frame", a, LIM);
    endtask

    task automatic t_late();
        int d, jlen, off;
        bit seen = 1'b0;
        frame_req = 1'b1;
        wait_tx(d, 300);
        step(SLOT + 4);
        collide(jlen, off);
        chk(jlen == JAMB, "R7 jam on late collision", jlen, JAMB);
        chk(drop && !retry, "R7 late drop no retry", {drop, retry}, 2);
        chk(drop_reason == 2'd2, "R7 late reason code", drop_reason, 2);
        frame_req = 1'b0;
        step(1);
        chk(!drop && drop_reason == 2'd0, "R10 drop single cycle", {drop, drop_reason}, 0);
        for (int i = 0; i < 3 * SLOT; i++) begin
            step(1);
            if (tx_en) seen = 1'b1;
        end
        chk(!seen, "R7 no retransmission", seen, 0);
    endtask

    task automatic t_fdx();
        int d;
        bit bad = 1'b0;
        full_duplex = 1'b1;
        crs = 1'b1;
        frame_req = 1'b1;
        wait_tx(d, 100);
        chk(tx_en, "R8 start despite carrier", tx_en, 1);
        col = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            if (jam || !tx_en) bad = 1'b1;
        end
        col = 1'b0;
        step(1);
        chk(!bad && tx_en && !jam, "R8 collision ignored", bad, 0);
        frame_done = 1'b1;
        step(1);
        frame_done = 1'b0;
        wait_tx(d, 200);
        chk(d >= IFG && d <= IFG + 3, "R8 gap only", d, IFG + 1);
        step(2);
        finish_frame();
        full_duplex = 1'b0;
        crs = 1'b0;
    endtask

    task automatic t_tick();
        int d;
        full_duplex = 1'b1;
        tick_every = 3;
        frame_req = 1'b1;
        wait_tx(d, 300);
        step(4);
        frame_done = 1'b1;
        step(1);
        frame_done = 1'b0;
        wait_tx(d, 300);
        chk(d >= 3 * IFG - 3 && d <= 3 * IFG + 6, "R9 gap in bit ticks", d, 3 * IFG);
        step(2);
        finish_frame();
        tick_every = 1;
        full_duplex = 1'b0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        report();
    end

    initial begin
        t_reset();
        t_gap();
        t_defer_crs();
        t_early_col();
        t_late();
        t_fdx();
        t_tick();
        t_limit();
        report();
    end
endmodule